// File: doc/BRIEF.md
# Wiper Position Register with Saturating Step Control

This block holds the volatile position of a 256-tap digital potentiometer wiper and turns that position into a one-hot set of tap-switch enables. Bit 0 of the tap enables connects the wiper to the low end of the resistor string. Bit 255 connects it to the high end. The analog string is outside the block. Only the select lines are produced here.

The position can change in four ways. A recall request copies stored register 0 into the wiper; a controller raises it once after power-up. A host write loads a byte directly. A transfer strobe copies one of the four stored bank-0 values, picked by a select field. Single-cycle step pulses move the wiper one tap up or down. An upstream serial decoder turns each serial clock pulse into a step pulse: a pulse taken with the data line high becomes a step up, and one taken with the data line low becomes a step down. It keeps doing this until chip select rises. The current position stays visible on an output so that the decoder can serve wiper reads and transfers into storage.

Top module: `wiper_counter_reg`

## Requirements
- R1: While `rst_n` is low, `wiper_pos` is 0x00 and only `tap_en[0]` is set. This happens at once, without waiting for a clock edge.
- R2: After reset, exactly one bit of `tap_en` is high, and its index equals `wiper_pos`. Bit 0 is the low-terminal tap and bit 255 is the high-terminal tap.
- R3: A cycle with `recall_req` high loads `bank0_vals[7:0]` (stored register 0) into the position at the next edge. This overrides every other strobe in that cycle.
- R4: A cycle with `wr_stb` high and `recall_req` low loads `wr_data` at the next edge.
- R5: A cycle with `xfer_stb` high, and neither `recall_req` nor `wr_stb` high, loads `bank0_vals[8*xfer_sel +: 8]` at the next edge. Select 0 gives bits 7:0 and select 3 gives bits 31:24.
- R6: When no load strobe is active, a cycle with only `step_up` high adds one to the position. A cycle with only `step_dn` high subtracts one. There is one step per strobed cycle.
- R7: Stepping saturates. A step up at 0xFF leaves 0xFF, and a step down at 0x00 leaves 0x00.
- R8: Any load strobe (recall, write or transfer) takes priority over step strobes in the same cycle. A cycle with `step_up` and `step_dn` both high and no load leaves the position unchanged.
- R9: A cycle with no strobe leaves the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| recall_req | input | 1 | Load stored register 0 (power-up recall) |
| wr_stb | input | 1 | Direct write strobe |
| wr_data | input | 8 | Direct write value |
| xfer_stb | input | 1 | Transfer strobe from a stored bank-0 register |
| xfer_sel | input | 2 | Index of the stored register to transfer |
| bank0_vals | input | 32 | Four stored bank-0 values, register n in bits 8n+7:8n |
| step_up | input | 1 | Single-step toward the high terminal |
| step_dn | input | 1 | Single-step toward the low terminal |
| wiper_pos | output | 8 | Current wiper position |
| tap_en | output | 256 | One-hot tap switch enables |

## Verification
The hardest cases to reach are the two ends of the range reached by stepping, because the clamp only acts when a step arrives exactly at 0x00 or 0xFF. The bench gets there in two ways. It writes 0xFE and then steps twice. It also sweeps 300 step pulses in each direction from a written start, checking the position and the one-hot tap after every pulse. Cycles with several strobes at once are also reached only on purpose, so the vector table combines recall, write, transfer and both step strobes in the same cycle to expose the priority order.

// File: rtl/wcr_pkg.sv
package wcr_pkg;

  // Origin of the next wiper position, in priority order after HOLD.
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_WRITE  = 3'd2,
    SRC_XFER   = 3'd3,
    SRC_STEP   = 3'd4
  } wcr_src_e;

endpackage

// File: rtl/wcr_src_arb.sv
module wcr_src_arb
  import wcr_pkg::*;
(
  input  logic     recall_req,
  input  logic     wr_stb,
  input  logic     xfer_stb,
  input  logic     step_up,
  input  logic     step_dn,
  output wcr_src_e src
);

  logic step_any;

  // Opposite step strobes in the same cycle cancel.
  assign step_any = step_up ^ step_dn;

  always_comb begin
    if (recall_req)    src = SRC_RECALL;
    else if (wr_stb)   src = SRC_WRITE;
    else if (xfer_stb) src = SRC_XFER;
    else if (step_any) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

endmodule

// File: rtl/wcr_step.sv
module wcr_step #(
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] pos,
  input  logic             up,
  output logic [POS_W-1:0] stepped
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic at_top;
  logic at_bot;

  assign at_top = (pos == POS_MAX);
  assign at_bot = (pos == POS_MIN);

  always_comb begin
    stepped = pos;
    if (up) begin
      if (!at_top) stepped = pos + 1'b1;
    end else begin
      if (!at_bot) stepped = pos - 1'b1;
    end
  end

endmodule

// File: rtl/wcr_tap_decode.sv
module wcr_tap_decode #(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_en
);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_en[t] = (pos == t[POS_W-1:0]);
  end

endmodule

// File: rtl/wiper_counter_reg.sv
module wiper_counter_reg
  import wcr_pkg::*;
#(
  parameter int POS_W       = 8,
  parameter int N_BANK_REGS = 4,
  localparam int SEL_W      = $clog2(N_BANK_REGS),
  localparam int TAPS       = 1 << POS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         recall_req,
  input  logic                         wr_stb,
  input  logic [POS_W-1:0]             wr_data,
  input  logic                         xfer_stb,
  input  logic [SEL_W-1:0]             xfer_sel,
  input  logic [N_BANK_REGS*POS_W-1:0] bank0_vals,
  input  logic                         step_up,
  input  logic                         step_dn,
  output logic [POS_W-1:0]             wiper_pos,
  output logic [TAPS-1:0]              tap_en
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  // Stored bank-0 values, unpacked.
  logic [POS_W-1:0] bank_reg [N_BANK_REGS];

  for (genvar r = 0; r < N_BANK_REGS; r++) begin : g_bank
    assign bank_reg[r] = bank0_vals[r*POS_W +: POS_W];
  end

  wcr_src_e         src;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic             pos_en;
  logic [POS_W-1:0] stepped;

  wcr_src_arb u_arb (
    .recall_req (recall_req),
    .wr_stb     (wr_stb),
    .xfer_stb   (xfer_stb),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .src        (src)
  );

  wcr_step #(.POS_W(POS_W)) u_step (
    .pos     (pos_q),
    .up      (step_up),
    .stepped (stepped)
  );

  // Next-state selection.
  always_comb begin
    pos_en = 1'b1;
    pos_d  = pos_q;
    unique case (src)
      SRC_RECALL: pos_d = bank_reg[0];
      SRC_WRITE:  pos_d = wr_data;
      SRC_XFER:   pos_d = bank_reg[xfer_sel];
      SRC_STEP:   pos_d = stepped;
      default:    pos_en = 1'b0;
    endcase
  end

  // Position register.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pos_q <= '0;
    else if (pos_en)  pos_q <= pos_d;
  end

  assign wiper_pos = pos_q;

  wcr_tap_decode #(.POS_W(POS_W)) u_dec (
    .pos    (pos_q),
    .tap_en (tap_en)
  );

  // Checks next to the register they guard.
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(tap_en) == 1 && tap_en[wiper_pos]);

  p_recall_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    recall_req |=> wiper_pos == $past(bank0_vals[POS_W-1:0]));

  p_write_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && !recall_req) |=> wiper_pos == $past(wr_data));

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_up && !step_dn && !recall_req && !wr_stb && !xfer_stb
     && wiper_pos != POS_MAX) |=> wiper_pos == $past(wiper_pos) + 1'b1);

  p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_up && !step_dn && !recall_req && !wr_stb && !xfer_stb
     && wiper_pos == POS_MAX) |=> wiper_pos == POS_MAX);

  p_sat_bot_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_dn && !step_up && !recall_req && !wr_stb && !xfer_stb
     && wiper_pos == '0) |=> wiper_pos == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!recall_req && !wr_stb && !xfer_stb && (step_up == step_dn))
    |=> $stable(wiper_pos));

endmodule

// File: tb/wiper_counter_reg_tb.sv
module wiper_counter_reg_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         recall_req, wr_stb, xfer_stb, step_up, step_dn;
  logic [7:0]   wr_data;
  logic [1:0]   xfer_sel;
  logic [31:0]  bank0_vals;
  logic [7:0]   wiper_pos;
  logic [255:0] tap_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wiper_counter_reg u_dut (
    .clk(clk), .rst_n(rst_n), .recall_req(recall_req), .wr_stb(wr_stb),
    .wr_data(wr_data), .xfer_stb(xfer_stb), .xfer_sel(xfer_sel),
    .bank0_vals(bank0_vals), .step_up(step_up), .step_dn(step_dn),
    .wiper_pos(wiper_pos), .tap_en(tap_en)
  );

  // Stored values: reg0=A5 reg1=11 reg2=7E reg3=C3
  localparam logic [31:0] BANK = 32'hC3_7E_11_A5;

  // {recall, wr, wdata, xfer, sel, up, dn, expected}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'hA6},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 8'hA5},
    {1'b0, 1'b1, 8'hFE, 1'b0, 2'd0, 1'b0, 1'b0, 8'hFE},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h11},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 8'h10},
    {1'b0, 1'b1, 8'h01, 1'b0, 2'd0, 1'b1, 1'b0, 8'h01},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 1'b0, 1'b1, 8'hC3},
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'hC3},
    {1'b1, 1'b1, 8'h33, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 8'h42, 1'b1, 2'd2, 1'b0, 1'b0, 8'h42},
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 8'h7E},
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 8'hA5}
  };

  string vtag [NV];

  task automatic check_pos(input logic [7:0] exp, input string tag);
    checks++;
    if (wiper_pos !== exp) begin
      errors++;
      $display("FAIL %s: wiper_pos actual %h expected %h", tag, wiper_pos, exp);
    end
    checks++;
    if (tap_en !== (256'b1 << exp)) begin
      errors++;
      $display("FAIL R2 (%s): tap_en actual %h expected one-hot bit %0d",
               tag, tap_en, exp);
    end
  endtask

  task automatic idle_inputs();
    recall_req = 1'b0; wr_stb = 1'b0; xfer_stb = 1'b0;
    step_up = 1'b0; step_dn = 1'b0; wr_data = 8'h00; xfer_sel = 2'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    vtag = '{"R3", "R6", "R6", "R4", "R6", "R7", "R5", "R6", "R8",
             "R6", "R7", "R8", "R8", "R9", "R3", "R8", "R5", "R5"};
    bank0_vals = BANK;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_pos(8'h00, "R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_pos(8'h00, "R1 after release");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      {recall_req, wr_stb, wr_data, xfer_stb, xfer_sel, step_up, step_dn} =
        VEC[i][22:8];
      @(negedge clk);
      check_pos(VEC[i][7:0], vtag[i]);
    end
    idle_inputs();

    // Sweep up from 0x00 through saturation (R6, R7)
    wr_stb = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    idle_inputs();
    for (int n = 1; n <= 300; n++) begin
      step_up = 1'b1;
      @(negedge clk);
      check_pos((n > 255) ? 8'hFF : n[7:0], (n > 255) ? "R7 top" : "R6 up");
    end
    // Sweep down through saturation
    step_up = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      step_dn = 1'b1;
      @(negedge clk);
      check_pos((n > 255) ? 8'h00 : 8'(255 - n), (n > 255) ? "R7 bottom" : "R6 down");
    end
    idle_inputs();

    // Idle hold (R9)
    wr_stb = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    idle_inputs();
    repeat (4) @(negedge clk);
    check_pos(8'h5A, "R9 hold");

    // Asynchronous reset mid-run (R1)
    #3 rst_n = 1'b0;
    #1 check_pos(8'h00, "R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    recall_req = 1'b1;
    @(negedge clk);
    idle_inputs();
    check_pos(8'hA5, "R3 recall after reset");

    finish_run();
  end

endmodule